// File: doc/BRIEF.md
# Colour-Bar YUV Video Pattern Generator

This block is a synthetic video source that runs in the pixel clock domain. It produces a raster with a frame sync, a line sync, a data-enable and a 16-bit YUV 4:2:2 pixel bus. The picture is a set of vertical colour bars. The bars can stand still or scroll sideways by one pixel per frame.

Every timing value is an input: frame rate, line and data gaps, horizontal blanking, and active width and height. The settings are sampled once per frame, so a setting that changes mid-frame takes effect at the next frame boundary. The parameter `CLK_HZ` is the pixel clock frequency. The frame period is derived from it by a rate accumulator, so no divider is needed.

Top module: `yuv_pattern_gen`

## Requirements
- R1: While rst_ni is low, vsync_o, hsync_o, de_o and pixel_o are all 0. The first frame begins in the cycle that follows the first rising clock edge after rst_ni goes high: vsync_o is 1 in that cycle.
- R2: All inputs are sampled only at a frame boundary. A change made during a frame leaves the rest of that frame unchanged and applies from the next frame.
- R3: The rate input gives frames per CLK_HZ clock cycles, and a rate of 0 acts as 1. Each frame lasts either the floor or the ceiling of CLK_HZ/rate cycles, and the fractional part is carried from frame to frame.
- R4: A line lasts L = data_start_gap + width + data_end_gap + hblank cycles. Line 0 of a frame is the sync line: vsync_o is 1 for all L cycles of it, and hsync_o and de_o are 0 during it.
- R5: Lines 1 to height are active lines. On an active line, counting the cycle within the line h from 0, de_o is 1 for data_start_gap <= h < data_start_gap + width.
- R6: On an active line, hsync_o is 1 for line_start_gap <= h < data_start_gap + width + data_end_gap - line_end_gap.
- R7: pixel_o[7:0] carries luma and pixel_o[15:8] carries chroma. Chroma is Cb on even output columns x and Cr on odd ones, where x = h - data_start_gap. pixel_o is 0 whenever de_o is 0.
- R8: Output column x shows pattern column p = (x + offset) mod width. Its bar index is floor(p*n/width), where n is the bar count. The (Y,Cb,Cr) values for bar index 0 to 7 are: (235,128,128), (210,16,146), (170,166,16), (145,54,34), (106,202,222), (81,90,240), (41,240,110), (16,128,128).
- R9: The bar code bars_i selects the bar count n: 2'b00 gives 8, 2'b01 gives 7, 2'b10 gives 5 and 2'b11 gives 3. Width must be at least 8.
- R10: With fixed_i = 1 the offset is 0. With fixed_i = 0 the offset in the k-th frame is k mod width. Counting restarts from 0 with the first frame after reset, after a change from fixed to moving, or after a change of width or bar code.
- R11: Lines after line height, up to the end of the frame, are blank: vsync_o, hsync_o and de_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 8 | Frames per second; 0 acts as 1 |
| fixed_i | input | 1 | 1 = bars stand still, 0 = bars scroll |
| bars_i | input | 2 | Bar count code |
| line_start_gap_i | input | 8 | Cycles from line start to hsync rise |
| line_end_gap_i | input | 8 | Cycles from hsync fall to the end of the data end gap |
| data_start_gap_i | input | 8 | Cycles from line start to the first active pixel |
| data_end_gap_i | input | 8 | Cycles after the last active pixel, before blanking |
| hblank_i | input | 16 | Horizontal blanking cycles at the end of each line |
| act_width_i | input | 16 | Active pixels per line |
| act_height_i | input | 16 | Active lines per frame |
| vsync_o | output | 1 | Frame sync, high for the sync line |
| hsync_o | output | 1 | Line sync window on active lines |
| de_o | output | 1 | Data enable for active pixels |
| pixel_o | output | 16 | {chroma, luma} |

## Verification
Two things can happen on the same pixel: the scroll offset can wrap back to zero at a frame boundary, and the pattern column can wrap from width-1 to 0 inside a line. When the offset is width-1, the column wrap falls on the very first active pixel of every line. The bench runs the moving pattern for more than width consecutive frames, so both wraps occur. It compares every pixel of every frame with the closed-form bar index from R8, computed by division in the bench, so an off-by-one in either wrap shows up as a wrong colour or chroma phase at a known column.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam int unsigned DIM_W  = 16;
  localparam int unsigned GAP_W  = 8;
  localparam int unsigned HBL_W  = 16;
  localparam int unsigned RATE_W = 8;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned BAR_W  = 3;
  localparam int unsigned PIX_W  = 16;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              fixed;
    logic [CODE_W-1:0] bars;
    logic [GAP_W-1:0]  lsg;
    logic [GAP_W-1:0]  leg;
    logic [GAP_W-1:0]  dsg;
    logic [GAP_W-1:0]  deg;
    logic [HBL_W-1:0]  hblank;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    rate: 8'd60, fixed: 1'b0, bars: 2'b00,
    lsg: 8'd8, leg: 8'd4, dsg: 8'd8, deg: 8'd4,
    hblank: 16'd16, width: 16'd640, height: 16'd480
  };

  // column tracker: bar = floor(col*n/width), rem = col*n - bar*width
  typedef struct packed {
    logic [DIM_W-1:0] col;
    logic [BAR_W-1:0] bar;
    logic [DIM_W-1:0] rem;
  } trk_t;

  function automatic logic [BAR_W:0] bar_count(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   return 4'd8;
      2'b01:   return 4'd7;
      2'b10:   return 4'd5;
      default: return 4'd3;
    endcase
  endfunction

  function automatic trk_t trk_next(input trk_t t, input logic [DIM_W-1:0] width,
                                    input logic [BAR_W:0] n);
    trk_t o;
    logic [DIM_W:0] sum;
    sum = {1'b0, t.rem} + (DIM_W+1)'(n);
    if (t.col == width - 1'b1) begin
      o = '0;
    end else begin
      o.col = t.col + 1'b1;
      if (sum >= {1'b0, width}) begin
        o.bar = t.bar + 1'b1;
        o.rem = DIM_W'(sum - {1'b0, width});
      end else begin
        o.bar = t.bar;
        o.rem = sum[DIM_W-1:0];
      end
    end
    return o;
  endfunction

  // {Y, Cb, Cr}
  function automatic logic [23:0] bar_yuv(input logic [BAR_W-1:0] idx);
    case (idx)
      3'd0:    return {8'd235, 8'd128, 8'd128};
      3'd1:    return {8'd210, 8'd16,  8'd146};
      3'd2:    return {8'd170, 8'd166, 8'd16};
      3'd3:    return {8'd145, 8'd54,  8'd34};
      3'd4:    return {8'd106, 8'd202, 8'd222};
      3'd5:    return {8'd81,  8'd90,  8'd240};
      3'd6:    return {8'd41,  8'd240, 8'd110};
      default: return {8'd16,  8'd128, 8'd128};
    endcase
  endfunction
endpackage

// File: rtl/vpg_frame_timer.sv
module vpg_frame_timer #(
  parameter int unsigned CLK_HZ = 27_000_000,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o,
  output logic              first_o
);
  localparam int unsigned ACC_W = $clog2(CLK_HZ + (1 << RATE_W)) + 1;

  logic              start_q;
  logic [ACC_W-1:0]  acc_q, acc_sum;
  logic [RATE_W-1:0] rate_eff;
  logic              hit;

  assign rate_eff = (rate_i == '0) ? RATE_W'(1) : rate_i;
  assign acc_sum  = acc_q + ACC_W'(rate_eff);
  assign hit      = acc_sum >= ACC_W'(CLK_HZ);
  assign tick_o   = start_q | hit;
  assign first_o  = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      acc_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (start_q)  acc_q <= '0;
      else if (hit) acc_q <= acc_sum - ACC_W'(CLK_HZ);
      else          acc_q <= acc_sum;
    end
  end
endmodule

// File: rtl/vpg_raster.sv
module vpg_raster #(
  parameter int unsigned DIM_W = 16,
  parameter int unsigned GAP_W = 8,
  parameter int unsigned HBL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [GAP_W-1:0] lsg_i,
  input  logic [GAP_W-1:0] leg_i,
  input  logic [GAP_W-1:0] dsg_i,
  input  logic [GAP_W-1:0] deg_i,
  input  logic [HBL_W-1:0] hblank_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic             vsync_o,
  output logic             hsync_o,
  output logic             de_o
);
  localparam int unsigned LINE_W = ((DIM_W > HBL_W) ? DIM_W : HBL_W) + 2;

  logic [LINE_W-1:0] h_q, de_beg, de_end, line_len, hs_end;
  logic [DIM_W:0]    v_q;
  logic              active, last_h, v_run;

  assign de_beg   = LINE_W'(dsg_i);
  assign de_end   = de_beg + LINE_W'(width_i);
  assign line_len = de_end + LINE_W'(deg_i) + LINE_W'(hblank_i);
  assign hs_end   = de_end + LINE_W'(deg_i) - LINE_W'(leg_i);
  assign last_h   = (h_q == line_len - 1'b1);
  assign v_run    = (v_q <= {1'b0, height_i});

  assign active  = (v_q != '0) && v_run;
  assign vsync_o = (v_q == '0);
  assign hsync_o = active && (h_q >= LINE_W'(lsg_i)) && (h_q < hs_end);
  assign de_o    = active && (h_q >= de_beg) && (h_q < de_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '1;  // parked in blank until the first frame starts
    end else if (tick_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (last_h) begin
      h_q <= '0;
      if (v_run) v_q <= v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end
endmodule

// File: rtl/vpg_scroll.sv
module vpg_scroll
  import vpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             first_i,
  input  logic             moving_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [BAR_W:0]   nbars_i,
  input  logic             prev_moving_i,
  input  logic [DIM_W-1:0] prev_width_i,
  input  logic [BAR_W:0]   prev_nbars_i,
  output trk_t             start_o
);
  trk_t start_q;
  logic restart;

  assign restart = first_i || !moving_i || !prev_moving_i ||
                   (width_i != prev_width_i) || (nbars_i != prev_nbars_i);
  assign start_o = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          start_q <= '0;
    else if (tick_i) begin
      if (restart)        start_q <= '0;
      else                start_q <= trk_next(start_q, width_i, nbars_i);
    end
  end
endmodule

// File: rtl/vpg_bar_painter.sv
module vpg_bar_painter
  import vpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             de_i,
  input  trk_t             start_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [BAR_W:0]   nbars_i,
  output logic [PIX_W-1:0] pixel_o
);
  trk_t        cur_q;
  logic        odd_q;
  logic [23:0] yuv;

  assign yuv     = bar_yuv(cur_q.bar);
  assign pixel_o = de_i ? {(odd_q ? yuv[7:0] : yuv[15:8]), yuv[23:16]} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      odd_q <= 1'b0;
    end else if (!de_i) begin
      cur_q <= start_i;
      odd_q <= 1'b0;
    end else begin
      cur_q <= trk_next(cur_q, width_i, nbars_i);
      odd_q <= ~odd_q;
    end
  end
endmodule

// File: rtl/yuv_pattern_gen.sv
module yuv_pattern_gen
  import vpg_pkg::*;
#(
  parameter int unsigned CLK_HZ = 27_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rate_i,
  input  logic        fixed_i,
  input  logic [1:0]  bars_i,
  input  logic [7:0]  line_start_gap_i,
  input  logic [7:0]  line_end_gap_i,
  input  logic [7:0]  data_start_gap_i,
  input  logic [7:0]  data_end_gap_i,
  input  logic [15:0] hblank_i,
  input  logic [15:0] act_width_i,
  input  logic [15:0] act_height_i,
  output logic        vsync_o,
  output logic        hsync_o,
  output logic        de_o,
  output logic [15:0] pixel_o
);
  cfg_t           cfg_in, cfg_q;
  logic           frame_tick, frame_first;
  logic [BAR_W:0] nbars_in, nbars_q;
  trk_t           start_trk;

  assign cfg_in = '{
    rate: rate_i, fixed: fixed_i, bars: bars_i,
    lsg: line_start_gap_i, leg: line_end_gap_i,
    dsg: data_start_gap_i, deg: data_end_gap_i,
    hblank: hblank_i, width: act_width_i, height: act_height_i
  };
  assign nbars_in = bar_count(cfg_in.bars);
  assign nbars_q  = bar_count(cfg_q.bars);

  // settings shadow, reloaded only at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= CFG_RESET;
    else if (frame_tick) cfg_q <= cfg_in;
  end

  vpg_frame_timer #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(cfg_q.rate),
    .tick_o(frame_tick), .first_o(frame_first)
  );

  vpg_raster #(.DIM_W(DIM_W), .GAP_W(GAP_W), .HBL_W(HBL_W)) u_raster (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(frame_tick),
    .lsg_i(cfg_q.lsg), .leg_i(cfg_q.leg), .dsg_i(cfg_q.dsg), .deg_i(cfg_q.deg),
    .hblank_i(cfg_q.hblank), .width_i(cfg_q.width), .height_i(cfg_q.height),
    .vsync_o(vsync_o), .hsync_o(hsync_o), .de_o(de_o)
  );

  vpg_scroll u_scroll (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(frame_tick), .first_i(frame_first),
    .moving_i(!cfg_in.fixed), .width_i(cfg_in.width), .nbars_i(nbars_in),
    .prev_moving_i(!cfg_q.fixed), .prev_width_i(cfg_q.width), .prev_nbars_i(nbars_q),
    .start_o(start_trk)
  );

  vpg_bar_painter u_painter (
    .clk_i(clk_i), .rst_ni(rst_ni), .de_i(de_o), .start_i(start_trk),
    .width_i(cfg_q.width), .nbars_i(nbars_q), .pixel_o(pixel_o)
  );
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
  parameter int unsigned CLK_HZ = 27_000_000,
  parameter int unsigned DIM_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             vsync_i,
  input logic             hsync_i,
  input logic             de_i,
  input logic [15:0]      pixel_i,
  input logic [DIM_W-1:0] width_i
);
  logic [DIM_W:0] de_run_q;
  logic [31:0]    frm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_run_q <= '0;
      frm_q    <= '0;
    end else begin
      de_run_q <= de_i ? de_run_q + 1'b1 : '0;
      if (tick_i)             frm_q <= 32'd1;
      else if (frm_q != '1)   frm_q <= frm_q + 1'b1;
    end
  end

  p_sync_line_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |-> (!hsync_i && !de_i));

  p_tick_opens_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> vsync_i);

  p_blank_pixel_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> (pixel_i == 16'h0000));

  p_de_run_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!de_i && $past(de_i)) |-> (de_run_q == {1'b0, width_i}));

  p_frame_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (frm_q <= CLK_HZ));
endmodule

bind yuv_pattern_gen vpg_checker #(.CLK_HZ(CLK_HZ), .DIM_W(16)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(frame_tick),
  .vsync_i(vsync_o), .hsync_i(hsync_o), .de_i(de_o),
  .pixel_i(pixel_o), .width_i(cfg_q.width)
);

// File: tb/yuv_pattern_gen_tb.sv
module yuv_pattern_gen_tb;
  localparam int unsigned HZ = 6000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rate_i;
  logic        fixed_i;
  logic [1:0]  bars_i;
  logic [7:0]  line_start_gap_i, line_end_gap_i, data_start_gap_i, data_end_gap_i;
  logic [15:0] hblank_i, act_width_i, act_height_i;
  logic        vsync_o, hsync_o, de_o;
  logic [15:0] pixel_o;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 0;
  bit at_start = 0;
  int m_rate, m_fixed, m_bars, m_lsg, m_leg, m_dsg, m_deg, m_hb, m_w, m_h;

  always #10 clk_i = ~clk_i;

  yuv_pattern_gen #(.CLK_HZ(HZ)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(rate_i), .fixed_i(fixed_i), .bars_i(bars_i),
    .line_start_gap_i(line_start_gap_i), .line_end_gap_i(line_end_gap_i),
    .data_start_gap_i(data_start_gap_i), .data_end_gap_i(data_end_gap_i),
    .hblank_i(hblank_i), .act_width_i(act_width_i), .act_height_i(act_height_i),
    .vsync_o(vsync_o), .hsync_o(hsync_o), .de_o(de_o), .pixel_o(pixel_o)
  );

  function automatic int nbars(int code);
    case (code)
      0: return 8;
      1: return 7;
      2: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic logic [23:0] yuv_ref(int b);
    case (b)
      0: return 24'hEB_80_80;
      1: return 24'hD2_10_92;
      2: return 24'hAA_A6_10;
      3: return 24'h91_36_22;
      4: return 24'h6A_CA_DE;
      5: return 24'h51_5A_F0;
      6: return 24'h29_F0_6E;
      default: return 24'h10_80_80;
    endcase
  endfunction

  task automatic report(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_inputs();
    rate_i = 8'(m_rate); fixed_i = 1'(m_fixed); bars_i = 2'(m_bars);
    line_start_gap_i = 8'(m_lsg); line_end_gap_i = 8'(m_leg);
    data_start_gap_i = 8'(m_dsg); data_end_gap_i = 8'(m_deg);
    hblank_i = 16'(m_hb); act_width_i = 16'(m_w); act_height_i = 16'(m_h);
  endtask

  task automatic apply_cfg();
    @(negedge clk_i);
    drive_inputs();
    at_start = 0;
  endtask

  task automatic sync_frame();
    logic prev;
    if (!at_start) begin
      prev = vsync_o;
      forever begin
        @(negedge clk_i);
        if (vsync_o && !prev) break;
        prev = vsync_o;
      end
    end
    at_start = 0;
  endtask

  // walks one frame from its first cycle, comparing against the model
  task automatic check_frame(string req, int off, int flen);
    int L, n, v, h, x, p, b;
    bit evs, ehs, ede, act, t_ok, p_ok;
    logic [2:0]  t_act, t_exp;
    logic [15:0] p_act, p_exp, epix;
    logic [23:0] c;
    L = m_dsg + m_w + m_deg + m_hb;
    n = nbars(m_bars);
    t_ok = 1; p_ok = 1;
    t_act = '0; t_exp = '0; p_act = '0; p_exp = '0;
    for (int cyc = 0; cyc < flen; cyc++) begin
      v = cyc / L; h = cyc % L;
      act = (v >= 1) && (v <= m_h);
      evs = (v == 0);
      ehs = act && (h >= m_lsg) && (h < m_dsg + m_w + m_deg - m_leg);
      ede = act && (h >= m_dsg) && (h < m_dsg + m_w);
      epix = '0;
      if (ede) begin
        x = h - m_dsg;
        p = (x + off) % m_w;
        b = (p * n) / m_w;
        c = yuv_ref(b);
        epix = {((x % 2) == 0) ? c[15:8] : c[7:0], c[23:16]};
      end
      if (t_ok && ({vsync_o, hsync_o, de_o} !== {evs, ehs, ede})) begin
        t_ok = 0; t_act = {vsync_o, hsync_o, de_o}; t_exp = {evs, ehs, ede};
      end
      if (p_ok && (pixel_o !== epix)) begin
        p_ok = 0; p_act = pixel_o; p_exp = epix;
      end
      @(negedge clk_i);
    end
    if (t_ok && vsync_o !== 1'b1) begin
      t_ok = 0; t_act = {vsync_o, hsync_o, de_o}; t_exp = 3'b100;
    end
    report(t_ok, req, "syncs {vs,hs,de}", 32'(t_act), 32'(t_exp));
    report(p_ok, req, "pixel", 32'(p_act), 32'(p_exp));
    at_start = 1;
  endtask

  task automatic measure(output int len);
    logic prev;
    prev = 1'b1;
    len = 0;
    forever begin
      @(negedge clk_i);
      len++;
      if (vsync_o && !prev) break;
      prev = vsync_o;
    end
    at_start = 1;
  endtask

  task automatic base_cfg();
    m_rate = 20; m_fixed = 1; m_bars = 0;
    m_lsg = 8; m_leg = 4; m_dsg = 8; m_deg = 4; m_hb = 16; m_w = 16; m_h = 4;
  endtask

  // R1: outputs quiet in reset, first frame right after first edge
  task automatic t_reset();
    base_cfg();
    drive_inputs();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    report({vsync_o, hsync_o, de_o, pixel_o} === 19'h0, "R1", "outputs in reset",
           32'({vsync_o, hsync_o, de_o, pixel_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    report(vsync_o === 1'b1, "R1", "vsync after first edge", 32'(vsync_o), 32'h1);
    at_start = 1;
    check_frame("R4 R5 R6 R7 R8 R11 R3 first frame", 0, 300);
  endtask

  task automatic t_bars();
    for (int code = 1; code < 4; code++) begin
      m_bars = code;
      apply_cfg();
      sync_frame();
      check_frame("R9 R8 bar code", 0, 300);
    end
    m_bars = 0;
  endtask

  task automatic t_gaps();
    m_lsg = 2; m_leg = 1; m_dsg = 5; m_deg = 3; m_hb = 7; m_h = 3;
    apply_cfg();
    sync_frame();
    check_frame("R6 R5 R4 R11 gaps", 0, 300);
    base_cfg();
    apply_cfg();
    sync_frame();
    check_frame("R6 restored gaps", 0, 300);
  endtask

  // R10: offset wraps after width frames; column wrap lands on first pixel
  task automatic t_moving();
    m_fixed = 0;
    apply_cfg();
    sync_frame();
    for (int k = 0; k < 18; k++) check_frame("R10 scroll", k % m_w, 300);
  endtask

  // R2: change made inside a frame waits for the boundary
  task automatic t_midframe();
    sync_frame();
    fixed_i = 1'b1;
    bars_i  = 2'd3;
    check_frame("R2 old settings hold", 18 % m_w, 300);
    m_fixed = 1; m_bars = 3;
    check_frame("R2 R10 new settings", 0, 300);
  endtask

  task automatic t_rate();
    int len, sum;
    for (int r = 0; r < 2; r++) begin
      m_rate = r;
      apply_cfg();
      sync_frame();
      measure(len);
      report(len == HZ, "R3", "frame length rate 0/1", 32'(len), 32'(HZ));
    end
    m_rate = 7;
    apply_cfg();
    sync_frame();
    sum = 0;
    for (int k = 0; k < 7; k++) begin
      measure(len);
      sum += len;
      report(len == 857 || len == 858, "R3", "frame length rate 7", 32'(len), 32'd858);
    end
    report(sum >= HZ - 1 && sum <= HZ + 1, "R3", "seven frames total", 32'(sum), 32'(HZ));
  endtask

  initial begin
    t_reset();
    t_bars();
    t_gaps();
    t_moving();
    t_midframe();
    t_rate();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule